// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block moves bytes out of the currently selected configuration item and into system memory. It works from a 16-byte descriptor that software leaves in memory. Software writes the descriptor's 64-bit address into a small register window. The engine then does the following in order:

- reads the descriptor over its byte-wide memory master;
- optionally asks the companion selector block to switch to a new item;
- copies bytes, skips bytes, or zero-fills past the item's end;
- rewrites the descriptor's control word in place to report how the transfer ended.

The companion selector owns the item store and the current read offset. The engine sees those as input pins: a valid flag, the item length, the current offset and the byte at that offset. It drives two one-cycle strobes back to the companion. `sel_stb` (with `sel_key`) selects a new item and zeroes its offset. `adv_stb` moves the offset on by one byte.

The descriptor is big-endian and has three fields:

| Descriptor offset | Size | Field |
|---|---|---|
| +0 | 4 bytes | control word |
| +4 | 4 bytes | length |
| +8 | 8 bytes | target address |

The memory master is a valid/ready channel with one byte per beat. `mem_req` is valid and `mem_gnt` is ready. A beat completes in a cycle where both are high. Read data and the per-beat error flag are valid in that same cycle. While `mem_req` is high and `mem_gnt` is low, the engine holds `mem_we`, `mem_addr` and `mem_wdata` unchanged and keeps the request up. The memory may stall for any number of cycles.

Top module: `cfgdma_engine`

## Requirements
- R1: The descriptor address can be loaded in either of two ways. One way is a 4-byte write at offset 0, which sets the high half and zeroes the low half, followed by a 4-byte write at offset 4, which ORs in the low half. The other way is a single 8-byte write at offset 0. Only the offset-4 write or the 8-byte write starts a transfer.
- R2: Any other register write is refused: `reg_wr_err` is high in that cycle and no transfer starts. Any register write while `busy` is high is also refused.
- R3: The address register is cleared when a transfer starts, so a later low-half-only write produces a descriptor address whose high half is zero.
- R4: A transfer first reads the 16 descriptor bytes at ascending addresses starting from the descriptor address, using mem_we=0.
- R5: Control bits are: error=bit0, read=bit1, skip=bit2, select=bit3. If read is set, the transfer is a read even when skip is also set. If neither read nor skip is set, no data moves.
- R6: If the select bit is set, a single `sel_stb` carrying control bits 31:16 as `sel_key` is issued before any data beat.
- R7: In a read, each byte still inside the item is written to the target address (ascending from the descriptor's target), and each such byte gives one `adv_stb`.
- R8: Once the item is exhausted (offset >= length) or the item is not valid, a read writes zero bytes for the rest of the length and gives no `adv_stb`. A skip gives one `adv_stb` per in-item byte, stops at the item's end, and makes no memory access.
- R9: A transfer ends with four byte writes at descriptor address +0..+3. These hold the big-endian control word: 0x00000000 on success, or 0x00000001 if a data write got `mem_err`. Data movement stops at the first errored beat.
- R10: If a descriptor read gets `mem_err`, the fetch stops there and the error status is written back at once, with no selection and no data movement.
- R11: A register read of `reg_rd_size` bytes at `reg_rd_offset` returns, right-aligned, those bytes of the 64-bit big-endian constant 0x4346_4758_4645_5231. A read that runs past byte 7 returns zero.
- R12: `busy` rises in the cycle after a starting write and falls only after the last write-back beat. `mem_req` is never high while `busy` is low, and a stalled request holds its fields until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_offset | input | 3 | Byte offset of the write |
| reg_wr_size | input | 4 | Write size in bytes |
| reg_wr_data | input | 64 | Write data, right-aligned |
| reg_wr_err | output | 1 | Write refused (combinational) |
| reg_rd_offset | input | 3 | Byte offset of a signature read |
| reg_rd_size | input | 4 | Read size in bytes |
| reg_rd_data | output | 64 | Signature bytes, right-aligned |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory beat valid |
| mem_gnt | input | 1 | Memory beat ready |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with grant |
| mem_err | input | 1 | Beat failed, valid with grant |
| item_valid | input | 1 | Current selection refers to an item |
| item_len | input | ITEM_W | Current item length in bytes |
| item_off | input | ITEM_W | Current offset in the item |
| item_byte | input | 8 | Item byte at item_off |
| sel_stb | output | 1 | Select item sel_key and zero its offset |
| sel_key | output | 16 | Key to select |
| adv_stb | output | 1 | Advance item offset by one |

## Verification
The assertions make three assumptions about the environment:

- Once the memory has seen a request, it answers within the same cycle: grant, read data and error are all combinational on the request.
- The companion applies `sel_stb` and `adv_stb` at the next clock edge, so the item inputs are steady while a request is stalled.
- Software does not hammer the register window while a transfer runs.

The stimulus respects these assumptions. The bench's memory and selector models sample the engine's outputs just after the falling edge and update only on the rising edge. The stall pattern withholds grant on a fixed subset of cycles. Register writes during a transfer are made only where the refusal itself is what the test checks.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned CTL_W      = 32;
  localparam int unsigned KEY_W      = 16;
  localparam int unsigned DESC_BYTES = 16;
  localparam int unsigned STAT_BYTES = 4;

  localparam int unsigned CTL_ERR  = 0;
  localparam int unsigned CTL_READ = 1;
  localparam int unsigned CTL_SKIP = 2;
  localparam int unsigned CTL_SEL  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_MOVE,
    ST_WBACK
  } xfer_state_e;
endpackage

// File: rtl/cfgdma_regs.sv
module cfgdma_regs
  import cfgdma_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SIG = 64'h4346_4758_4645_5231
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_off,
  input  logic [3:0]        wr_size,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              busy,
  output logic              wr_err,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        rd_off,
  input  logic [3:0]        rd_size,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int unsigned HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] addr_q, addr_nxt;
  logic is_hi, is_lo, is_full, legal, accept;

  assign is_hi   = (wr_size == 4'd4) && (wr_off == 3'd0);
  assign is_lo   = (wr_size == 4'd4) && (wr_off == 3'd4);
  assign is_full = (wr_size == 4'd8) && (wr_off == 3'd0);
  assign legal   = is_hi || is_lo || is_full;
  assign accept  = wr_en && legal && !busy;
  assign wr_err  = wr_en && !(legal && !busy);
  assign start   = accept && (is_lo || is_full);

  always_comb begin
    addr_nxt = addr_q;
    if (is_hi)      addr_nxt = {wr_data[HALF-1:0], {HALF{1'b0}}};
    else if (is_lo) addr_nxt = addr_q | {{HALF{1'b0}}, wr_data[HALF-1:0]};
    else if (is_full) addr_nxt = wr_data;
  end
  assign start_addr = addr_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= start ? '0 : addr_nxt;
  end

  // signature window: big-endian byte slice, right-aligned
  logic [4:0]        span;
  logic [7:0]        shamt;
  logic [ADDR_W-1:0] mask;
  logic              rd_ok;
  assign span  = {2'b00, rd_off} + {1'b0, rd_size};
  assign rd_ok = (rd_size != 4'd0) && (span <= 5'd8);
  assign shamt = {5'd8 - span, 3'b000};
  assign mask  = ~({ADDR_W{1'b1}} << {rd_size, 3'b000});
  assign rd_data = rd_ok ? ((SIG >> shamt) & mask) : '0;
endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
  import cfgdma_pkg::*;
#(
  parameter int unsigned ITEM_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err,
  input  logic              item_valid,
  input  logic [ITEM_W-1:0] item_len,
  input  logic [ITEM_W-1:0] item_off,
  input  logic [7:0]        item_byte,
  output logic              sel_stb,
  output logic [KEY_W-1:0]  sel_key,
  output logic              adv_stb
);
  localparam int unsigned BUF_W  = DESC_BYTES * 8;
  localparam int unsigned CNT_W  = $clog2(DESC_BYTES);
  localparam int unsigned LEN_W  = 32;
  localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(DESC_BYTES - 1);
  localparam logic [CNT_W-1:0] WB_LAST    = CNT_W'(STAT_BYTES - 1);

  xfer_state_e       state_q;
  logic [ADDR_W-1:0] desc_q, tgt_q;
  logic [BUF_W-1:0]  buf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  rem_q;
  logic              rd_mode_q, status_q;
  logic [CTL_W-1:0]  ctl;
  logic              in_item, beat, moving;

  assign ctl     = buf_q[BUF_W-1 -: CTL_W];
  assign in_item = item_valid && (item_off < item_len);
  assign moving  = (state_q == ST_MOVE) && (rem_q != '0);
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b1;
    mem_addr  = desc_q + ADDR_W'(cnt_q);
    mem_wdata = 8'h00;
    unique case (state_q)
      ST_FETCH: begin mem_req = 1'b1; mem_we = 1'b0; end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_wdata = (cnt_q == WB_LAST) ? {7'b0, status_q} : 8'h00;
      end
      ST_MOVE: begin
        mem_req   = moving && rd_mode_q;
        mem_addr  = tgt_q;
        mem_wdata = in_item ? item_byte : 8'h00;
      end
      default: ;
    endcase
  end

  assign beat    = mem_req && mem_gnt;
  assign sel_stb = (state_q == ST_DECODE) && ctl[CTL_SEL];
  assign sel_key = ctl[CTL_W-1 -: KEY_W];
  assign adv_stb = moving && in_item && (rd_mode_q ? mem_gnt : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      desc_q    <= '0;
      tgt_q     <= '0;
      buf_q     <= '0;
      cnt_q     <= '0;
      rem_q     <= '0;
      rd_mode_q <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          desc_q   <= start_addr;
          cnt_q    <= '0;
          status_q <= 1'b0;
          state_q  <= ST_FETCH;
        end
        ST_FETCH: if (beat) begin
          buf_q <= {buf_q[BUF_W-9:0], mem_rdata};
          cnt_q <= cnt_q + 1'b1;
          if (mem_err) begin
            status_q <= 1'b1;
            cnt_q    <= '0;
            state_q  <= ST_WBACK;
          end else if (cnt_q == FETCH_LAST) begin
            state_q <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          tgt_q     <= buf_q[ADDR_W-1:0];
          rd_mode_q <= ctl[CTL_READ];
          rem_q     <= (ctl[CTL_READ] || ctl[CTL_SKIP]) ?
                       buf_q[ADDR_W +: LEN_W] : '0;
          cnt_q     <= '0;
          state_q   <= ST_MOVE;
        end
        ST_MOVE: begin
          if (rem_q == '0) begin
            cnt_q   <= '0;
            state_q <= ST_WBACK;
          end else if (rd_mode_q) begin
            if (beat) begin
              tgt_q <= tgt_q + 1'b1;
              rem_q <= rem_q - 1'b1;
              if (mem_err) begin
                status_q <= 1'b1;
                state_q  <= ST_WBACK;
              end
            end
          end else begin
            rem_q <= in_item ? rem_q - 1'b1 : '0;
          end
        end
        ST_WBACK: if (beat) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == WB_LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_ctl;
  assign unused_ctl = ^{ctl[CTL_W-KEY_W-1:CTL_SEL+1], ctl[CTL_ERR]};
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter int unsigned ITEM_W = 32,
  parameter logic [63:0] SIG    = 64'h4346_4758_4645_5231
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_wr_offset,
  input  logic [3:0]        reg_wr_size,
  input  logic [63:0]       reg_wr_data,
  output logic              reg_wr_err,
  input  logic [2:0]        reg_rd_offset,
  input  logic [3:0]        reg_rd_size,
  output logic [63:0]       reg_rd_data,
  output logic              busy,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_err,
  input  logic              item_valid,
  input  logic [ITEM_W-1:0] item_len,
  input  logic [ITEM_W-1:0] item_off,
  input  logic [7:0]        item_byte,
  output logic              sel_stb,
  output logic [15:0]       sel_key,
  output logic              adv_stb
);
  logic              start;
  logic [ADDR_W-1:0] start_addr;

  cfgdma_regs #(.SIG(SIG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_off(reg_wr_offset), .wr_size(reg_wr_size),
    .wr_data(reg_wr_data), .busy(busy), .wr_err(reg_wr_err),
    .start(start), .start_addr(start_addr),
    .rd_off(reg_rd_offset), .rd_size(reg_rd_size), .rd_data(reg_rd_data)
  );

  cfgdma_seq #(.ITEM_W(ITEM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .item_valid(item_valid), .item_len(item_len),
    .item_off(item_off), .item_byte(item_byte), .sel_stb(sel_stb),
    .sel_key(sel_key), .adv_stb(adv_stb)
  );
endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_err,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_gnt,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        sel_stb,
  input logic        adv_stb
);
  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_we) &&
                            $stable(mem_addr) && $stable(mem_wdata));

  // R12
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_req && mem_gnt && mem_we));

  // R12
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R2
  refused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_err && !busy |=> !busy);

  // R6
  select_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb |-> busy && !mem_req && !adv_stb);

  // R8
  advance_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_stb |-> busy);
endmodule

bind cfgdma_engine cfgdma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_err(reg_wr_err), .busy(busy),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sel_stb(sel_stb),
  .adv_stb(adv_stb)
);

// File: tb/cfgdma_engine_test.sv
module cfgdma_engine_test;
  localparam logic [1:0] EV_MEM = 2'd0, EV_SEL = 2'd1, EV_ADV = 2'd2;

  typedef struct packed {
    logic [1:0]  kind;
    logic        we;
    logic [63:0] addr;
    logic [7:0]  data;
  } ev_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  logic        reg_wr_en = 0, reg_wr_err;
  logic [2:0]  reg_wr_offset = 0, reg_rd_offset = 0;
  logic [3:0]  reg_wr_size = 0, reg_rd_size = 0;
  logic [63:0] reg_wr_data = 0, reg_rd_data;
  logic        busy, mem_req, mem_gnt = 0, mem_we, mem_err = 0;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = 0;
  logic        sel_stb, adv_stb;
  logic [15:0] sel_key;
  logic        item_valid;
  logic [31:0] item_len, item_off;
  logic [7:0]  item_byte;

  cfgdma_engine uut (.*);

  // companion selector model
  logic [15:0] key_q = 16'd2, key_n = 16'd2;
  logic [31:0] off_q = 0, off_n = 0;
  always @(posedge clk) begin key_q <= key_n; off_q <= off_n; end
  assign item_valid = key_q < 16'd8;
  assign item_len   = 32'(key_q) * 32'd3;
  assign item_off   = off_q;
  assign item_byte  = {key_q[3:0], off_q[3:0]} ^ 8'hA5;

  logic [7:0]  mem [logic [63:0]];
  ev_t         exq[$];
  string       tq[$];
  int          errors = 0, checks = 0, cyc = 0;
  logic        err_on = 0, err_we = 0;
  logic [63:0] err_addr = 0;
  logic [15:0] mkey = 16'd2;
  int          moff = 0;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic w, input logic [63:0] a,
                      input logic [7:0] d, input string t);
    ev_t e;
    e.kind = k; e.we = w; e.addr = a; e.data = d;
    exq.push_back(e); tq.push_back(t);
  endtask

  task automatic observe(input logic [1:0] k, input logic w,
                         input logic [63:0] a, input logic [7:0] d);
    ev_t e;
    string t;
    if (exq.size() == 0) begin
      chk(0, "R12", "unexpected event", {62'b0, k}, 64'hFFFF);
    end else begin
      e = exq.pop_front(); t = tq.pop_front();
      chk(e.kind == k, t, "event kind", {62'b0, k}, {62'b0, e.kind});
      chk(e.we == w && e.addr == a && e.data == d, t, "event addr/data",
          {a[54:0], w, d}, {e.addr[54:0], e.we, e.data});
    end
  endtask

  // memory responder, monitor and companion next-state
  always begin
    @(negedge clk);
    #1;
    cyc++;
    mem_gnt   = mem_req && ((cyc % 4) != 2);
    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    mem_err   = mem_req && err_on && (mem_we == err_we) && (mem_addr == err_addr);
    #2;
    key_n = key_q; off_n = off_q;
    if (rst_n) begin
      if (sel_stb) begin
        observe(EV_SEL, 1'b0, {48'b0, sel_key}, 8'h00);
        key_n = sel_key; off_n = 0;
      end
      if (mem_req && mem_gnt) begin
        observe(EV_MEM, mem_we, mem_addr, mem_we ? mem_wdata : 8'h00);
        if (mem_we) mem[mem_addr] = mem_wdata;
      end
      if (adv_stb) begin
        observe(EV_ADV, 1'b0, 64'h0, 8'h00);
        off_n = off_q + 1;
      end
    end
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  task automatic put_desc(input logic [63:0] d, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [63:0] tgt);
    logic [127:0] img;
    img = {ctl, len, tgt};
    for (int i = 0; i < 16; i++) mem[d + 64'(i)] = img[127 - 8*i -: 8];
  endtask

  // reference expectations for one transfer
  task automatic model(input logic [63:0] d, input logic [31:0] ctl,
                       input logic [31:0] len, input logic [63:0] tgt,
                       input int ferr, input int werr);
    int  n;
    bit  inb, st;
    n  = (ferr >= 0) ? ferr + 1 : 16;
    st = (ferr >= 0);
    for (int i = 0; i < n; i++) push(EV_MEM, 1'b0, d + 64'(i), 8'h00, "R4");
    if (ferr < 0) begin
      if (ctl[3]) begin
        push(EV_SEL, 1'b0, {48'b0, ctl[31:16]}, 8'h00, "R6");
        mkey = ctl[31:16]; moff = 0;
      end
      if (ctl[1]) begin
        for (int i = 0; i < int'(len); i++) begin
          inb = (mkey < 16'd8) && (moff < int'(mkey) * 3);
          push(EV_MEM, 1'b1, tgt + 64'(i),
               inb ? ({mkey[3:0], 4'(moff)} ^ 8'hA5) : 8'h00, inb ? "R7" : "R8");
          if (inb) begin push(EV_ADV, 1'b0, 64'h0, 8'h00, "R7"); moff++; end
          if (werr == i) begin st = 1; break; end
        end
      end else if (ctl[2]) begin
        for (int i = 0; i < int'(len); i++) begin
          inb = (mkey < 16'd8) && (moff < int'(mkey) * 3);
          if (!inb) break;
          push(EV_ADV, 1'b0, 64'h0, 8'h00, "R8");
          moff++;
        end
      end
    end
    for (int i = 0; i < 4; i++)
      push(EV_MEM, 1'b1, d + 64'(i), (i == 3) ? {7'b0, st} : 8'h00, "R9");
    err_on   = (ferr >= 0) || (werr >= 0);
    err_we   = (werr >= 0);
    err_addr = (ferr >= 0) ? d + 64'(ferr) : tgt + 64'(werr);
  endtask

  task automatic wr(input logic [2:0] off, input logic [3:0] size,
                    input logic [63:0] data, input bit exp_err, input string t);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_offset = off; reg_wr_size = size; reg_wr_data = data;
    #2;
    chk(reg_wr_err == exp_err, t, "write refusal", {63'b0, reg_wr_err}, {63'b0, exp_err});
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic wait_done(input string t);
    #2;
    chk(busy == 1'b1, "R12", "busy after start", {63'b0, busy}, 64'd1);
    do begin @(negedge clk); #2; end while (busy);
    chk(exq.size() == 0, t, "events outstanding", 64'(exq.size()), 64'd0);
    err_on = 0;
  endtask

  task automatic run_full(input logic [63:0] d, input logic [31:0] ctl,
                          input logic [31:0] len, input logic [63:0] tgt,
                          input int ferr, input int werr, input string t);
    put_desc(d, ctl, len, tgt);
    model(d, ctl, len, tgt, ferr, werr);
    wr(3'd0, 4'd8, d, 1'b0, "R1");
    wait_done(t);
  endtask

  task automatic sig(input logic [2:0] off, input logic [3:0] size,
                     input logic [63:0] exp);
    @(negedge clk);
    reg_rd_offset = off; reg_rd_size = size;
    #1;
    chk(reg_rd_data == exp, "R11", "signature read", reg_rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(!busy && !mem_req && !reg_wr_err && !sel_stb && !adv_stb, "R12",
        "reset state", {60'b0, busy, mem_req, sel_stb, adv_stb}, 64'd0);

    sig(3'd0, 4'd8, 64'h4346_4758_4645_5231);
    sig(3'd0, 4'd4, 64'h4346_4758);
    sig(3'd4, 4'd4, 64'h4645_5231);
    sig(3'd2, 4'd2, 64'h4758);
    sig(3'd7, 4'd1, 64'h31);
    sig(3'd6, 4'd4, 64'h0);

    // R2: illegal sizes and offsets are refused and start nothing
    wr(3'd0, 4'd2, 64'h1000, 1'b1, "R2");
    wr(3'd2, 4'd4, 64'h1000, 1'b1, "R2");
    wr(3'd4, 4'd8, 64'h1000, 1'b1, "R2");
    @(negedge clk); #2;
    chk(!busy, "R2", "no start after refused writes", {63'b0, busy}, 64'd0);

    // R1 high/low halves, R6 select key 5, R7 copy
    put_desc(64'h1_0000_1000, 32'h0005_000A, 32'd10, 64'h2000);
    model(64'h1_0000_1000, 32'h0005_000A, 32'd10, 64'h2000, -1, -1);
    wr(3'd0, 4'd4, 64'h1, 1'b0, "R1");
    #2;
    chk(!busy, "R1", "high half alone does not start", {63'b0, busy}, 64'd0);
    wr(3'd4, 4'd4, 64'h1000, 1'b0, "R1");
    wait_done("R7");

    // R8: read runs past the item end -> zero fill
    run_full(64'h1100, 32'h0000_0002, 32'd8, 64'h3000, -1, -1, "R8");
    // R5/R8: skip, then read resumes at the new offset
    run_full(64'h1200, 32'h0004_000C, 32'd5, 64'h0, -1, -1, "R8");
    run_full(64'h1300, 32'h0000_0002, 32'd3, 64'h3100, -1, -1, "R7");
    // R8: skip beyond item end only advances in-item bytes
    run_full(64'h1400, 32'h0000_0004, 32'd20, 64'h0, -1, -1, "R8");
    // R5: read and skip both set -> read wins
    run_full(64'h1500, 32'h0003_000E, 32'd4, 64'h3200, -1, -1, "R5");
    // R5: neither read nor skip -> select only, no movement
    run_full(64'h1600, 32'h0001_0008, 32'd7, 64'h3300, -1, -1, "R5");
    // R9: write error at third data byte
    run_full(64'h1700, 32'h0000_0002, 32'd6, 64'h4000, -1, 2, "R9");
    chk(mem[64'h1703] == 8'h01, "R9", "error status byte", {56'b0, mem[64'h1703]}, 64'h01);
    // R10: descriptor fetch fails on its sixth byte
    run_full(64'h1A00, 32'h0002_000A, 32'd4, 64'h4100, 5, -1, "R10");
    chk(mem[64'h1A03] == 8'h01, "R10", "fetch error status", {56'b0, mem[64'h1A03]}, 64'h01);

    // R3: only a low half written; high half must read as zero
    put_desc(64'h1800, 32'h0007_000A, 32'd3, 64'h5000);
    model(64'h1800, 32'h0007_000A, 32'd3, 64'h5000, -1, -1);
    wr(3'd4, 4'd4, 64'h1800, 1'b0, "R3");
    wait_done("R3");

    // R8 invalid key; R2 writes while busy are refused
    put_desc(64'h1900, 32'h0009_000A, 32'd4, 64'h5100);
    model(64'h1900, 32'h0009_000A, 32'd4, 64'h5100, -1, -1);
    wr(3'd0, 4'd8, 64'h1900, 1'b0, "R1");
    wr(3'd4, 4'd4, 64'h1800, 1'b1, "R2");
    wait_done("R8");
    chk(mem[64'h1903] == 8'h00, "R9", "success status byte", {56'b0, mem[64'h1903]}, 64'h00);

    repeat (4) @(negedge clk);
    chk(exq.size() == 0 && !busy, "R2", "no transfer from refused write",
        64'(exq.size()), 64'd0);
    summary();
    $finish;
  end
endmodule